// File: doc/BRIEF.md
# Synchronous Burst Address Sequencer

This block sits at the address input of a synchronous burst cache memory of 65,536 words. On a rising clock edge it captures a 16-bit word address and three chip-enable inputs whenever one of its two address strobes is active. One strobe comes from the processor and the other from the cache controller. It then presents that address to the memory array as the first beat of a four-beat burst.

After the first beat, a 2-bit beat counter walks the two low address bits through the burst. It steps only when the advance input is asserted. A mode input chooses the order of the beats. In interleaved order each beat's low bits are the start bits XOR the beat number. In linear order they are the start bits plus the beat number, wrapping within the aligned group of four. The upper 14 address bits stay fixed for the whole burst. A registered chip-selected flag records whether the device was addressed at capture.

Top module: `burst_addr_seq`

## Requirements
- R1: While `rstN` is low, and on the first cycle after it rises with no strobe, `arrayAddr` is 0 and `chipSel` is 0.
- R2: When `ctrlStrobeN` is 0 at a rising edge, `arrayAddr` equals the sampled `wordAddr` after that edge, whatever the chip enables are.
- R3: When `procStrobeN` is 0 and `ce1N` is 0 at a rising edge, the address is loaded as in R2. When `procStrobeN` is 0 and `ce1N` is 1 with `ctrlStrobeN` at 1, both `arrayAddr` and `chipSel` keep their previous values.
- R4: On every load, `chipSel` becomes 1 exactly when `ce1N`=0, `ce2`=1 and `ce3N`=0 were sampled at that edge. Between loads it holds its value.
- R5: With no load, `advanceN`=0 moves the burst one beat per edge, and `advanceN`=1 holds `arrayAddr` unchanged.
- R6: When `interleave` is 1 at the load edge, beat n (n = 0..3) has low bits `arrayAddr[1:0]` = start[1:0] XOR n.
- R7: When `interleave` is 0 at the load edge, beat n has low bits `arrayAddr[1:0]` = (start[1:0] + n) mod 4.
- R8: The ordering is fixed by the mode sampled at the load, and a change of `interleave` during the burst has no effect. `arrayAddr[15:2]` never changes between loads. One advance after beat 3 returns to the start address.
- R9: A load takes priority over advance. A strobe in mid-burst abandons the burst and starts a new one at beat 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Active-low synchronous reset |
| wordAddr | input | 16 | Word address sampled on a load |
| procStrobeN | input | 1 | Processor address strobe, active low, gated by ce1N |
| ctrlStrobeN | input | 1 | Controller address strobe, active low, always loads |
| advanceN | input | 1 | Burst advance, active low |
| ce1N | input | 1 | Chip enable 1, active low |
| ce2 | input | 1 | Chip enable 2, active high |
| ce3N | input | 1 | Chip enable 3, active low |
| interleave | input | 1 | Burst order: 1 interleaved, 0 linear |
| arrayAddr | output | 16 | Current array word address |
| chipSel | output | 1 | Registered device-selected flag |

## Verification
Bursts are run from every start offset in both orders. This separates XOR stepping from additive stepping, because the two differ for the start offsets 1 and 3. Wrap-around past beat 3 and mid-burst suspends show whether the counter stays inside its aligned group of four and really holds.

Processor strobes are given with CE1 both asserted and deasserted, and controller strobes are given with the enables deasserted. This shows the gating of one strobe against the other. Strobes that coincide with advance, and toggling of the mode input mid-burst, show the load priority and that the order is captured with the address.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  // Strobes from the control to the datapath
  typedef struct packed {
    logic load;  // capture a new start address, beat returns to 0
    logic step;  // move one beat forward
  } seqCtl_t;
endpackage

// File: rtl/burst_seq_ctrl.sv
module burst_seq_ctrl
  import burst_seq_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    procStrobeN,
  input  logic    ctrlStrobeN,
  input  logic    advanceN,
  input  logic    ce1N,
  input  logic    ce2,
  input  logic    ce3N,
  output seqCtl_t ctl,
  output logic    chipSel
);
  logic procHit;
  logic ctrlHit;
  logic selNow;

  always_comb begin
    procHit  = !procStrobeN && !ce1N;
    ctrlHit  = !ctrlStrobeN;
    ctl.load = procHit || ctrlHit;
    ctl.step = !ctl.load && !advanceN;
    selNow   = !ce1N && ce2 && !ce3N;
  end

  always_ff @(posedge clk) begin
    if (!rstN)         chipSel <= 1'b0;
    else if (ctl.load) chipSel <= selNow;
  end

  // R4
  sel_capture_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.load |=> (chipSel == $past(!ce1N && ce2 && !ce3N)));

  // R3
  proc_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlStrobeN && ce1N) |=> $stable(chipSel));
endmodule

// File: rtl/burst_seq_datapath.sv
module burst_seq_datapath
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqCtl_t           ctl,
  input  logic [ADDR_W-1:0] wordAddr,
  input  logic              interleave,
  output logic [ADDR_W-1:0] arrayAddr
);
  localparam int UPPER_W = ADDR_W - CNT_W;

  logic [UPPER_W-1:0] upperQ;
  logic [CNT_W-1:0]   startQ;
  logic [CNT_W-1:0]   beatQ;
  logic               modeQ;
  logic [CNT_W-1:0]   lowXor;
  logic [CNT_W-1:0]   lowAdd;
  logic [CNT_W-1:0]   lowSel;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      upperQ <= '0;
      startQ <= '0;
      beatQ  <= '0;
      modeQ  <= 1'b0;
    end else if (ctl.load) begin
      upperQ <= wordAddr[ADDR_W-1:CNT_W];
      startQ <= wordAddr[CNT_W-1:0];
      beatQ  <= '0;
      modeQ  <= interleave;
    end else if (ctl.step) begin
      beatQ  <= beatQ + 1'b1;
    end
  end

  // Interleaved order: one XOR per low address bit
  for (genvar b = 0; b < CNT_W; b++) begin : g_xorBit
    assign lowXor[b] = startQ[b] ^ beatQ[b];
  end

  assign lowAdd    = startQ + beatQ;
  assign lowSel    = modeQ ? lowXor : lowAdd;
  assign arrayAddr = {upperQ, lowSel};

  // R2
  load_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.load |=> (arrayAddr == $past(wordAddr)));

  // R5
  hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.load && !ctl.step) |=> $stable(arrayAddr));

  // R8
  upper_fixed_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.load |=> (arrayAddr[ADDR_W-1:CNT_W] == $past(arrayAddr[ADDR_W-1:CNT_W])));

  // R7
  linear_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.step && !modeQ) |=>
      (arrayAddr[CNT_W-1:0] == CNT_W'($past(arrayAddr[CNT_W-1:0]) + 1'b1)));
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_seq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [15:0] wordAddr,
  input  logic        procStrobeN,
  input  logic        ctrlStrobeN,
  input  logic        advanceN,
  input  logic        ce1N,
  input  logic        ce2,
  input  logic        ce3N,
  input  logic        interleave,
  output logic [15:0] arrayAddr,
  output logic        chipSel
);
  seqCtl_t ctl;

  burst_seq_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .procStrobeN (procStrobeN),
    .ctrlStrobeN (ctrlStrobeN),
    .advanceN    (advanceN),
    .ce1N        (ce1N),
    .ce2         (ce2),
    .ce3N        (ce3N),
    .ctl         (ctl),
    .chipSel     (chipSel)
  );

  burst_seq_datapath #(.ADDR_W(16), .CNT_W(2)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .wordAddr   (wordAddr),
    .interleave (interleave),
    .arrayAddr  (arrayAddr)
  );

  // R1
  reset_state_chk: assert property (@(posedge clk)
    !rstN |=> (arrayAddr == 16'h0000 && chipSel == 1'b0));
endmodule

// File: tb/burst_addr_seq_bench.sv
module burst_addr_seq_bench;
  localparam int PERIOD = 10;
  localparam int NVEC   = 18;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] wordAddr = '0;
  logic        procStrobeN = 1'b1, ctrlStrobeN = 1'b1, advanceN = 1'b1;
  logic        ce1N = 1'b1, ce2 = 1'b0, ce3N = 1'b1, interleave = 1'b0;
  logic [15:0] arrayAddr;
  logic        chipSel;

  int checks = 0;
  int fails  = 0;

  always #(PERIOD/2) clk = ~clk;

  burst_addr_seq u_burst_addr_seq (
    .clk(clk), .rstN(rstN), .wordAddr(wordAddr),
    .procStrobeN(procStrobeN), .ctrlStrobeN(ctrlStrobeN), .advanceN(advanceN),
    .ce1N(ce1N), .ce2(ce2), .ce3N(ce3N), .interleave(interleave),
    .arrayAddr(arrayAddr), .chipSel(chipSel)
  );

  // Fields: ctrlN procN advN ce1N ce2 ce3N mode | addr | expected addr | expected sel
  localparam logic [39:0] VEC [NVEC] = '{
    {7'b0_1_1_0_1_0_1, 16'h1235, 16'h1235, 1'b1}, // R2 controller load, interleaved
    {7'b1_1_0_0_1_0_1, 16'h0000, 16'h1234, 1'b1}, // R6 beat 1: 01^1
    {7'b1_1_0_0_1_0_1, 16'h0000, 16'h1237, 1'b1}, // R6 beat 2: 01^2
    {7'b1_1_0_0_1_0_1, 16'h0000, 16'h1236, 1'b1}, // R6 beat 3: 01^3
    {7'b1_1_0_0_1_0_1, 16'h0000, 16'h1235, 1'b1}, // R8 wrap to start
    {7'b1_1_1_0_1_0_1, 16'h0000, 16'h1235, 1'b1}, // R5 suspend holds
    {7'b0_1_1_1_1_0_0, 16'hABCE, 16'hABCE, 1'b0}, // R2 controller loads with ce1N high, R4 sel 0
    {7'b1_1_0_1_1_0_0, 16'h0000, 16'hABCF, 1'b0}, // R7 linear beat 1
    {7'b1_1_0_1_1_0_0, 16'h0000, 16'hABCC, 1'b0}, // R7 wrap inside group
    {7'b1_1_0_1_1_0_0, 16'h0000, 16'hABCD, 1'b0}, // R7 beat 3
    {7'b1_0_1_1_1_0_0, 16'h5555, 16'hABCD, 1'b0}, // R3 proc strobe ignored with ce1N high
    {7'b1_0_1_0_1_0_0, 16'h0F03, 16'h0F03, 1'b1}, // R3 proc load, R4 sel 1
    {7'b1_1_0_0_1_0_0, 16'h0000, 16'h0F00, 1'b1}, // R7 linear from 3
    {7'b1_0_0_0_0_0_0, 16'h2222, 16'h2222, 1'b0}, // R9 load beats advance, R4 ce2 low
    {7'b0_1_1_0_1_1_1, 16'hFFFF, 16'hFFFF, 1'b0}, // R4 ce3N high deselects
    {7'b1_1_0_0_1_0_1, 16'h0000, 16'hFFFE, 1'b0}, // R6 11^1
    {7'b1_1_0_0_1_0_0, 16'h0000, 16'hFFFD, 1'b0}, // R8 mode change ignored: 11^2
    {7'b1_1_0_0_1_0_0, 16'h0000, 16'hFFFC, 1'b0}  // R8 mode change ignored: 11^3
  };

  task automatic checkOut(input string tag, input logic [15:0] expAddr, input logic expSel);
    checks++;
    if (arrayAddr !== expAddr || chipSel !== expSel) begin
      fails++;
      $display("FAIL %s: addr=%h sel=%b expected addr=%h sel=%b",
               tag, arrayAddr, chipSel, expAddr, expSel);
    end
  endtask

  task automatic idle();
    ctrlStrobeN = 1'b1; procStrobeN = 1'b1; advanceN = 1'b1;
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  initial begin
    #(PERIOD * 100000);
    fails++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    // R1 reset state
    tick(); tick();
    checkOut("R1 in reset", 16'h0000, 1'b0);
    rstN = 1'b1;
    tick();
    checkOut("R1 after reset release", 16'h0000, 1'b0);

    // Table walk
    for (int i = 0; i < NVEC; i++) begin
      {ctrlStrobeN, procStrobeN, advanceN, ce1N, ce2, ce3N, interleave} = VEC[i][39:33];
      wordAddr = VEC[i][32:17];
      tick();
      checkOut($sformatf("R2..R9 table row %0d", i), VEC[i][16:1], VEC[i][0]);
    end

    // Every start offset in both orders, with wrap (R6 R7 R8)
    for (int m = 0; m < 2; m++) begin
      for (int s = 0; s < 4; s++) begin
        idle();
        ctrlStrobeN = 1'b0; ce1N = 1'b0; ce2 = 1'b1; ce3N = 1'b0;
        interleave = m[0];
        wordAddr = {14'h1A2B, s[1:0]};
        tick();
        checkOut("R2 sweep load", {14'h1A2B, s[1:0]}, 1'b1);
        idle(); advanceN = 1'b0;
        for (int n = 1; n <= 4; n++) begin
          logic [1:0] expLow;
          interleave = ~interleave;
          expLow = m[0] ? (s[1:0] ^ n[1:0]) : (s[1:0] + n[1:0]);
          tick();
          checkOut(m[0] ? "R6 interleaved sweep" : "R7 linear sweep",
                   {14'h1A2B, expLow}, 1'b1);
        end
      end
    end

    // R5 long suspend mid-burst, then resume (start 2 linear: 2,3 hold,0)
    idle(); ctrlStrobeN = 1'b0; interleave = 1'b0; wordAddr = 16'h7776;
    tick();
    idle(); advanceN = 1'b0; tick();
    checkOut("R5 step", 16'h7777, 1'b1);
    idle();
    for (int k = 0; k < 3; k++) begin
      wordAddr = 16'h0101;
      tick();
      checkOut("R5 suspend", 16'h7777, 1'b1);
    end
    advanceN = 1'b0; tick();
    checkOut("R5 resume", 16'h7774, 1'b1);

    // R9 controller strobe mid-burst restarts at beat 0
    idle(); ctrlStrobeN = 1'b0; advanceN = 1'b0; wordAddr = 16'h4441;
    tick();
    checkOut("R9 restart", 16'h4441, 1'b1);

    // R1 reset mid-burst
    idle(); rstN = 1'b0; tick();
    checkOut("R1 reset mid-burst", 16'h0000, 1'b0);
    rstN = 1'b1; tick();
    checkOut("R1 idle after reset", 16'h0000, 1'b0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule